// File: doc/BRIEF.md
# Dual-pattern overlapping sequence detector

This block watches a single serial input `w`, taking one bit on every rising clock edge. It flags on output `z` each time the four most recent bits, oldest first, equal `1001` or `1111`. Both targets are tracked by one state machine. Matches may overlap, so the bits that end one hit can begin the next.

Each state records the longest tail of the received bits that is also a leading part of either target. Two extra states mark a completed hit, one for each target. The output is a Moore output, decoded from the state register only. A parameter selects binary or one-hot coding for the state register, and the behaviour at the ports is the same in both cases.

Top module: `dpd_seq_detect`

## Requirements
- R1: While `rst_n` is low, `z` is 0.
- R2: Reset is asynchronous. A falling edge on `rst_n` forces `z` to 0 at once, with no clock edge needed.
- R3: When the last four registered bits of `w`, oldest first, are 1,0,0,1, `z` is 1 during the clock cycle that follows the rising edge that captured the fourth bit.
- R4: When the last four registered bits of `w` are 1,1,1,1, `z` is 1 during the cycle after the edge that captured the fourth bit.
- R5: Overlapping `1001` hits count. The stream 1,0,0,1,0,0,1 gives hits after bit 4 and after bit 7.
- R6: Overlapping `1111` hits count. A run of n ones (n >= 4) gives n-3 consecutive cycles with `z` = 1.
- R7: In every other cycle `z` is 0. Windows such as 1011, 1101, 0111 and 1110 do not raise `z`, and each hit lasts exactly one cycle unless the next window also matches.
- R8: After reset, the detector acts as if no bits have been received. Bits taken in before reset never complete a match, so four new bits are needed before `z` can rise.
- R9: Parameter `STATE_CODING` selects the state register coding: 0 for binary, 1 for one-hot. Any other value stops elaboration. Both codings give identical `z` for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. `w` is sampled on the rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| w | input | 1 | Serial data input, one bit per clock. |
| z | output | 1 | High for one cycle per matching four-bit window. |

## Verification
The assertions check three things on every clocked cycle after reset. First, a shadow window of the last bits predicts `z` for each target pattern. Second, no non-matching window lets `z` rise. Third, the one-hot register always holds exactly one set bit. Only the bench scenarios can show the reset behaviour: that `z` clears between clock edges when reset falls, and that a partial pattern received before a reset is discarded. The bench also checks long overlapping runs against its own reference window, and compares the two state codings against each other.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

   // Each state is named after the longest received tail that starts either target.
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_1     = 3'd1,
      ST_10    = 3'd2,
      ST_100   = 3'd3,
      ST_11    = 3'd4,
      ST_111   = 3'd5,
      ST_HIT_A = 3'd6,   // just completed 1001
      ST_HIT_B = 3'd7    // just completed 1111
   } dpd_state_e;

   localparam int unsigned NUM_STATES = 8;
   localparam int unsigned WIN_LEN    = 4;
   localparam logic [WIN_LEN-1:0] PAT_A = 4'b1001;
   localparam logic [WIN_LEN-1:0] PAT_B = 4'b1111;

   function automatic dpd_state_e dpd_step(input dpd_state_e cur, input logic bit_in);
      dpd_state_e nxt;
      unique case (cur)
         ST_IDLE:  nxt = bit_in ? ST_1     : ST_IDLE;
         ST_1:     nxt = bit_in ? ST_11    : ST_10;
         ST_10:    nxt = bit_in ? ST_1     : ST_100;
         ST_100:   nxt = bit_in ? ST_HIT_A : ST_IDLE;
         ST_11:    nxt = bit_in ? ST_111   : ST_10;
         ST_111:   nxt = bit_in ? ST_HIT_B : ST_10;
         ST_HIT_A: nxt = bit_in ? ST_11    : ST_10;
         ST_HIT_B: nxt = bit_in ? ST_HIT_B : ST_10;
         default:  nxt = ST_IDLE;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/dpd_next_logic.sv
module dpd_next_logic
   import dpd_pkg::*;
(
   input  dpd_state_e cur_state,
   input  logic       bit_in,
   output dpd_state_e nxt_state
);

   always_comb begin
      nxt_state = dpd_step(cur_state, bit_in);
   end

endmodule

// File: rtl/dpd_state_store.sv
module dpd_state_store
   import dpd_pkg::*;
#(
   parameter int unsigned CODING = 0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  dpd_state_e d,
   output dpd_state_e q
);

   localparam int unsigned BIN_W = $clog2(NUM_STATES);
   localparam int unsigned OH_W  = NUM_STATES;

   generate
      if (CODING == 0) begin : g_binary
         logic [BIN_W-1:0] bin_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bin_q <= BIN_W'(ST_IDLE);
            else        bin_q <= BIN_W'(d);
         end

         assign q = dpd_state_e'(bin_q);
      end else if (CODING == 1) begin : g_onehot
         logic [OH_W-1:0] oh_q;
         logic [OH_W-1:0] oh_d;

         always_comb begin
            oh_d = '0;
            oh_d[int'(d)] = 1'b1;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oh_q <= OH_W'(1) << int'(ST_IDLE);
            else        oh_q <= oh_d;
         end

         always_comb begin
            q = ST_IDLE;
            for (int i = 0; i < OH_W; i++) begin
               if (oh_q[i]) q = dpd_state_e'(BIN_W'(i));
            end
         end

         // R9: the one-hot register keeps exactly one bit set
         p_onehot_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oh_q) == 1)
            else $error("one-hot state register lost its single set bit");
      end else begin : g_bad_coding
         $error("dpd_state_store: CODING must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/dpd_out_decode.sv
module dpd_out_decode
   import dpd_pkg::*;
(
   input  dpd_state_e state,
   output logic       hit
);

   always_comb begin
      hit = (state == ST_HIT_A) || (state == ST_HIT_B);
   end

endmodule

// File: rtl/dpd_seq_detect.sv
module dpd_seq_detect
   import dpd_pkg::*;
#(
   parameter int unsigned STATE_CODING = 0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic w,
   output logic z
);

   localparam int unsigned SEEN_W = $clog2(WIN_LEN);

   dpd_state_e cur_state;
   dpd_state_e nxt_state;

   dpd_next_logic u_next (
      .cur_state (cur_state),
      .bit_in    (w),
      .nxt_state (nxt_state)
   );

   dpd_state_store #(.CODING(STATE_CODING)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt_state),
      .q     (cur_state)
   );

   dpd_out_decode u_out (
      .state (cur_state),
      .hit   (z)
   );

   // Shadow history, used only to check the state machine against the raw bits.
   logic [WIN_LEN-2:0] shadow_q;
   logic [SEEN_W-1:0]  seen_q;
   logic [WIN_LEN-1:0] shadow_win;
   logic               shadow_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         seen_q   <= '0;
      end else begin
         shadow_q <= {shadow_q[WIN_LEN-3:0], w};
         if (seen_q != SEEN_W'(WIN_LEN-1)) seen_q <= seen_q + 1'b1;
      end
   end

   assign shadow_win  = {shadow_q, w};
   assign shadow_full = (seen_q == SEEN_W'(WIN_LEN-1));

   // R3: completing 1001 raises z in the next cycle
   p_hit_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_full && shadow_win == PAT_A) |=> z)
      else $error("1001 window did not raise z");

   // R4: completing 1111 raises z in the next cycle
   p_hit_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_full && shadow_win == PAT_B) |=> z)
      else $error("1111 window did not raise z");

   // R7, R8: no full matching window means z stays low
   p_no_false_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(shadow_full && (shadow_win == PAT_A || shadow_win == PAT_B)) |=> !z)
      else $error("z rose without a matching window");

endmodule

// File: tb/dpd_seq_detect_tb_top.sv
`timescale 1ns/1ps
module dpd_seq_detect_tb_top;

   localparam int    N_STREAM = 18;
   localparam real   HALF_PER = 10.0;
   localparam logic [N_STREAM-1:0] STREAM_BITS = 18'b010111100110011111;
   localparam logic [N_STREAM-1:0] STREAM_EXP  = 18'b000000100100010011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic w = 1'b0;
   logic z_bin, z_oh;

   int n_vec = 0;
   int n_bad = 0;
   logic [3:0] ref_win = '0;
   int         ref_cnt = 0;

   always #(HALF_PER) clk = ~clk;

   dpd_seq_detect #(.STATE_CODING(0)) dut_i (
      .clk (clk), .rst_n (rst_n), .w (w), .z (z_bin)
   );

   dpd_seq_detect #(.STATE_CODING(1)) dut_oh_i (
      .clk (clk), .rst_n (rst_n), .w (w), .z (z_oh)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: z=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic ref_z();
      return (ref_cnt >= 4) && (ref_win == 4'b1001 || ref_win == 4'b1111);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      w = 1'b0;
      ref_win = '0;
      ref_cnt = 0;
      repeat (2) @(negedge clk);
      chk(z_bin, 1'b0, "R1 binary");
      chk(z_oh,  1'b0, "R1 one-hot");
      rst_n = 1'b1;
   endtask

   // Drive one bit, let the edge capture it, then check z on both codings.
   task automatic send(input logic b, input logic exp, input string req);
      @(negedge clk);
      w = b;
      @(posedge clk);
      ref_win = {ref_win[2:0], b};
      ref_cnt++;
      #2;
      chk(z_bin, exp, req);
      chk(z_bin, ref_z(), {req, " ref-model"});
      chk(z_oh, z_bin, "R9 codings agree");
   endtask

   initial begin
      #(HALF_PER * 2 * 200000);
      n_bad++;
      $display("FAIL watchdog: run hung, z=%b expected completion", z_bin);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();

      // R3 R4 R7: the required stream, walked from the vector table
      for (int i = N_STREAM - 1; i >= 0; i--) begin
         send(STREAM_BITS[i], STREAM_EXP[i], "R3/R4/R7 stream");
      end

      // R5: overlapping 1001 hits after bits 4 and 7
      do_reset();
      send(1'b1, 1'b0, "R5"); send(1'b0, 1'b0, "R5"); send(1'b0, 1'b0, "R5");
      send(1'b1, 1'b1, "R5"); send(1'b0, 1'b0, "R5"); send(1'b0, 1'b0, "R5");
      send(1'b1, 1'b1, "R5");

      // R6: seven ones give four hits
      do_reset();
      for (int i = 1; i <= 7; i++) send(1'b1, (i >= 4), "R6");
      send(1'b0, 1'b0, "R6 run end");

      // R7: near-miss windows never fire
      do_reset();
      foreach (STREAM_BITS[i]) begin end
      send(1'b1, 1'b0, "R7"); send(1'b0, 1'b0, "R7"); send(1'b1, 1'b0, "R7");
      send(1'b1, 1'b0, "R7"); send(1'b1, 1'b0, "R7"); send(1'b0, 1'b0, "R7");
      send(1'b1, 1'b0, "R7"); send(1'b1, 1'b0, "R7");

      // R8: partial pattern before reset is discarded
      do_reset();
      send(1'b1, 1'b0, "R8"); send(1'b1, 1'b0, "R8"); send(1'b1, 1'b0, "R8");
      do_reset();
      send(1'b1, 1'b0, "R8 after reset");
      send(1'b1, 1'b0, "R8"); send(1'b1, 1'b0, "R8");
      send(1'b1, 1'b1, "R8 fourth new bit");

      // R2: reset falling between edges clears z at once
      send(1'b1, 1'b1, "R2 setup");
      @(negedge clk);
      chk(z_bin, 1'b1, "R2 before reset");
      rst_n = 1'b0;
      #1;
      chk(z_bin, 1'b0, "R2 binary");
      chk(z_oh,  1'b0, "R2 one-hot");
      ref_win = '0;
      ref_cnt = 0;
      @(negedge clk);
      rst_n = 1'b1;
      send(1'b0, 1'b0, "R8 post R2");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule